// File: doc/BRIEF.md
# Parallel Port Extended Control Register

This block is the byte-wide extended control register of a parallel port that can hand its data transfers to a hardware handshake engine. It sits on a simple register bus: a select from the address decode, a read strobe and a write strobe. A read returns the port mode, the error-interrupt enable, the service-interrupt mask and the live FIFO full and empty flags. A write updates the mode and the two interrupt controls.

Two interrupt pulses come out of the block. The error pulse follows the falling edge of the active-low fault input. It also fires when software clears the error enable while the fault is already low. The service pulse fires once when any service source is active and the mask is clear. Hardware then sets the mask again, so each service event needs a fresh software unmask.

The block also guards mode changes. A move from one non-programmed-I/O mode to a different one is refused and flagged. When the port leaves a handshake mode, the block sends a release pulse to the auto-feed strobe. If the FIFO still holds data at that point, the block flags a drain violation.

Top module: `pport_xctl`

## Requirements
- R1: After reset, a selected read returns 0x05 when the FIFO is empty and not full. The fields are mode in bits 7:5 = 000, error enable (active low) in bit 4 = 0, reserved bit 3 = 0, service mask in bit 2 = 1, full in bit 1 and empty in bit 0. A read while select or read strobe is low returns 0x00.
- R2: Bit 1 always shows `fifo_full_i` and bit 0 always shows `fifo_empty_i`. Writes to bits 3, 1 and 0 have no effect, and bit 3 always reads 0.
- R3: With bit 4 = 0, a falling edge on `fault_ni` gives a one-cycle `err_irq_o` pulse in the cycle after the edge is sampled. With bit 4 = 1 there is no pulse, and a rising edge never gives one.
- R4: A write that changes bit 4 from 1 to 0 while `fault_ni` is low gives a one-cycle `err_irq_o` pulse in the cycle after the write. A write of 0 over a 0 gives no pulse.
- R5: While bit 2 = 0, any active bit of `svc_src_i` gives exactly one one-cycle `svc_irq_o` pulse, and hardware sets bit 2 to 1 at the same edge.
- R6: While bit 2 = 1, service sources give no pulse. A write of 1 to bit 2 never produces a pulse.
- R7: A mode write is applied when the current mode is 000 or 001, when the requested mode is 000 or 001, or when the requested mode equals the current one. Any other request leaves the mode unchanged and sets the sticky `mode_err_o`, which only reset clears.
- R8: `hs_en_o` is high exactly while the mode is 010 or 011.
- R9: A write that moves the mode from 010 or 011 to 000 or 001 gives a one-cycle `afd_rel_o` pulse in the cycle after the write, whatever the FIFO state.
- R10: If `fifo_empty_i` is low during such a move, the move is still applied and the sticky `drain_err_o` is set. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register selected by address decode |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when not reading |
| fifo_full_i | input | 1 | FIFO cannot accept another byte |
| fifo_empty_i | input | 1 | FIFO holds no data |
| fault_ni | input | 1 | Peripheral fault, active low |
| svc_src_i | input | N_SVC | Service interrupt sources |
| err_irq_o | output | 1 | Error interrupt pulse |
| svc_irq_o | output | 1 | Service interrupt pulse |
| mode_o | output | 3 | Current port mode |
| hs_en_o | output | 1 | Hardware handshake enabled |
| afd_rel_o | output | 1 | Auto-feed release pulse |
| mode_err_o | output | 1 | Sticky refused mode change |
| drain_err_o | output | 1 | Sticky exit from handshake with data in FIFO |

## Verification
The bench builds the block with the default three service sources, so all seven non-zero source patterns are swept, each from reset. The 3-bit mode field is small enough to cover every pair of source and target modes, each with the FIFO both empty and not empty. That is 128 transitions, and each one is compared against an arithmetic model of the legality, release and drain rules. All four combinations of full and empty are read both before and after a write of all ones.

// File: rtl/pport_xctl_pkg.sv
package pport_xctl_pkg;
  localparam int REG_W      = 8;
  localparam int MODE_W     = 3;
  localparam int MODE_LSB   = 5;
  localparam int MODE_MSB   = MODE_LSB + MODE_W - 1;
  localparam int ERR_EN_BIT = 4;
  localparam int SVC_BIT    = 2;
  localparam int FULL_BIT   = 1;
  localparam int EMPTY_BIT  = 0;

  typedef enum logic [MODE_W-1:0] {
    PM_PIO_FWD = 3'b000,
    PM_PIO_BI  = 3'b001,
    PM_HS_A    = 3'b010,
    PM_HS_B    = 3'b011
  } pmode_e;

  function automatic logic is_pio(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:1] == '0;
  endfunction

  function automatic logic is_hs(input logic [MODE_W-1:0] m);
    return m[MODE_W-1:1] == PM_HS_A[MODE_W-1:1];
  endfunction
endpackage

// File: rtl/pport_mode_guard.sv
module pport_mode_guard
  import pport_xctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] req_i,
  input  logic              fifo_empty_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              hs_en_o,
  output logic              afd_rel_o,
  output logic              mode_err_o,
  output logic              drain_err_o
);
  logic [MODE_W-1:0] mode_q;
  logic legal, leave_hs, rel_q, merr_q, derr_q;

  // only the programmed-I/O modes may sit on either side of a change
  assign legal    = is_pio(mode_q) | is_pio(req_i) | (req_i == mode_q);
  assign leave_hs = wr_i & is_hs(mode_q) & is_pio(req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_PIO_FWD;
      rel_q  <= 1'b0;
      merr_q <= 1'b0;
      derr_q <= 1'b0;
    end else begin
      rel_q <= leave_hs;
      if (wr_i) begin
        if (legal) mode_q <= req_i;
        else       merr_q <= 1'b1;
      end
      if (leave_hs && !fifo_empty_i) derr_q <= 1'b1;
    end
  end

  assign mode_o      = mode_q;
  assign hs_en_o     = is_hs(mode_q);
  assign afd_rel_o   = rel_q;
  assign mode_err_o  = merr_q;
  assign drain_err_o = derr_q;
endmodule

// File: rtl/pport_fault_irq.sv
module pport_fault_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_ni,
  input  logic wr_i,
  input  logic wbit_i,
  output logic en_n_o,
  output logic err_irq_o
);
  logic fault_q, en_n_q, irq_q, fell, arm_low;

  assign fell    = fault_q & ~fault_ni & ~en_n_q;
  // enabling while the fault already sits low counts as an edge
  assign arm_low = wr_i & en_n_q & ~wbit_i & ~fault_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b1;
      en_n_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      fault_q <= fault_ni;
      irq_q   <= fell | arm_low;
      if (wr_i) en_n_q <= wbit_i;
    end
  end

  assign en_n_o    = en_n_q;
  assign err_irq_o = irq_q;
endmodule

// File: rtl/pport_svc_irq.sv
module pport_svc_irq #(
  parameter int N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_i,
  input  logic             wbit_i,
  output logic             mask_o,
  output logic             svc_irq_o
);
  logic mask_q, irq_q, fire;

  assign fire = ~mask_q & (|src_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fire;
      // hardware re-mask wins over a same-cycle software write
      if (fire)      mask_q <= 1'b1;
      else if (wr_i) mask_q <= wbit_i;
    end
  end

  assign mask_o    = mask_q;
  assign svc_irq_o = irq_q;
endmodule

// File: rtl/pport_xctl.sv
module pport_xctl
  import pport_xctl_pkg::*;
#(
  parameter int N_SVC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  input  logic              fault_ni,
  input  logic [N_SVC-1:0]  svc_src_i,
  output logic              err_irq_o,
  output logic              svc_irq_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              hs_en_o,
  output logic              afd_rel_o,
  output logic              mode_err_o,
  output logic              drain_err_o
);
  logic wr_hit, err_en_n, svc_mask;
  logic [MODE_W-1:0] mode;

  assign wr_hit = sel_i & wr_i;

  pport_mode_guard u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_hit),
    .req_i        (wdata_i[MODE_MSB:MODE_LSB]),
    .fifo_empty_i (fifo_empty_i),
    .mode_o       (mode),
    .hs_en_o      (hs_en_o),
    .afd_rel_o    (afd_rel_o),
    .mode_err_o   (mode_err_o),
    .drain_err_o  (drain_err_o)
  );

  pport_fault_irq u_fault (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_ni  (fault_ni),
    .wr_i      (wr_hit),
    .wbit_i    (wdata_i[ERR_EN_BIT]),
    .en_n_o    (err_en_n),
    .err_irq_o (err_irq_o)
  );

  pport_svc_irq #(.N_SRC(N_SVC)) u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (svc_src_i),
    .wr_i      (wr_hit),
    .wbit_i    (wdata_i[SVC_BIT]),
    .mask_o    (svc_mask),
    .svc_irq_o (svc_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      rdata_o[MODE_MSB:MODE_LSB] = mode;
      rdata_o[ERR_EN_BIT]        = err_en_n;
      rdata_o[SVC_BIT]           = svc_mask;
      rdata_o[FULL_BIT]          = fifo_full_i;
      rdata_o[EMPTY_BIT]         = fifo_empty_i;
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/pport_xctl_chk.sv
module pport_xctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fault_ni,
  input logic       err_en_n,
  input logic       err_irq_o,
  input logic       svc_mask,
  input logic       svc_irq_o,
  input logic [2:0] mode_o,
  input logic       hs_en_o,
  input logic       afd_rel_o,
  input logic       mode_err_o,
  input logic       drain_err_o
);
  // R3
  err_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fault_ni) && !err_en_n) |=> err_irq_o);

  // R5
  svc_remask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_irq_o |-> svc_mask);

  // R5
  svc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_irq_o |=> !svc_irq_o);

  // R7
  mode_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> ($past(mode_o) < 3'd2 || mode_o < 3'd2));

  // R7
  merr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |=> mode_err_o);

  // R9
  afd_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    afd_rel_o |-> (mode_o < 3'd2 && $past(hs_en_o)));

  // R10
  drain_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_err_o |=> drain_err_o);
endmodule

bind pport_xctl pport_xctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fault_ni    (fault_ni),
  .err_en_n    (err_en_n),
  .err_irq_o   (err_irq_o),
  .svc_mask    (svc_mask),
  .svc_irq_o   (svc_irq_o),
  .mode_o      (mode_o),
  .hs_en_o     (hs_en_o),
  .afd_rel_o   (afd_rel_o),
  .mode_err_o  (mode_err_o),
  .drain_err_o (drain_err_o)
);

// File: tb/pport_xctl_bench.sv
module pport_xctl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       full = 1'b0, empty = 1'b1, fault_n = 1'b1;
  logic [2:0] svc_src = '0;
  logic       err_irq, svc_irq, hs_en, afd_rel, mode_err, drain_err;
  logic [2:0] mode;
  int         n_chk = 0, n_err = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  pport_xctl #(.N_SVC(3)) u_pport_xctl (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .fifo_full_i(full), .fifo_empty_i(empty),
    .fault_ni(fault_n), .svc_src_i(svc_src), .err_irq_o(err_irq),
    .svc_irq_o(svc_irq), .mode_o(mode), .hs_en_o(hs_en), .afd_rel_o(afd_rel),
    .mode_err_o(mode_err), .drain_err_o(drain_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(output logic [7:0] v);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1;
    #1 v = rdata;
    sel = 1'b0; rd = 1'b0;
  endtask

  function automatic logic m_pio(input logic [2:0] m);
    return m < 3'd2;
  endfunction

  function automatic logic m_hs(input logic [2:0] m);
    return m == 3'd2 || m == 3'd3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state and idle read
    rd_reg(v);
    chk("R1 reset read", v, 8'h05);
    #1 chk("R1 idle read", rdata, 8'h00);
    chk("R8 reset hs", {7'd0, hs_en}, 8'd0);

    // R2 live status and ignored bits
    for (int i = 0; i < 4; i++) begin
      do_reset();
      full = i[1]; empty = i[0];
      rd_reg(v);
      chk("R2 status", v, {6'b000001, i[1:0]});
      wr_reg(8'hFF);
      rd_reg(v);
      chk("R2 ignored bits", v, {8'hF4 | {6'd0, i[1:0]}});
    end
    full = 1'b0; empty = 1'b1;

    // R3 fault edge
    do_reset();
    @(negedge clk) fault_n = 1'b0;
    @(negedge clk) chk("R3 fall pulse", {7'd0, err_irq}, 8'd1);
    @(negedge clk) chk("R3 pulse width", {7'd0, err_irq}, 8'd0);
    fault_n = 1'b1;
    @(negedge clk) chk("R3 rise quiet", {7'd0, err_irq}, 8'd0);
    @(negedge clk) chk("R3 rise quiet2", {7'd0, err_irq}, 8'd0);
    wr_reg(8'h14);
    @(negedge clk) fault_n = 1'b0;
    @(negedge clk) chk("R3 disabled fall", {7'd0, err_irq}, 8'd0);
    @(negedge clk) chk("R3 disabled fall2", {7'd0, err_irq}, 8'd0);
    // R4 enable while low
    wr_reg(8'h04);
    chk("R4 arm low pulse", {7'd0, err_irq}, 8'd1);
    @(negedge clk) chk("R4 pulse width", {7'd0, err_irq}, 8'd0);
    wr_reg(8'h04);
    chk("R4 zero over zero", {7'd0, err_irq}, 8'd0);
    fault_n = 1'b1;

    // R5 service pulse, every source pattern
    for (int p = 1; p < 8; p++) begin
      do_reset();
      wr_reg(8'h00);
      chk("R6 unmask quiet", {7'd0, svc_irq}, 8'd0);
      svc_src = p[2:0];
      @(negedge clk) chk("R5 svc pulse", {7'd0, svc_irq}, 8'd1);
      @(negedge clk) chk("R5 svc single", {7'd0, svc_irq}, 8'd0);
      rd_reg(v);
      chk("R5 hw remask", {7'd0, v[2]}, 8'd1);
      chk("R5 still single", {7'd0, svc_irq}, 8'd0);
      svc_src = '0;
    end

    // R6 masked sources and writing 1
    do_reset();
    svc_src = 3'b111;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) chk("R6 masked", {7'd0, svc_irq}, 8'd0);
    end
    svc_src = '0;
    wr_reg(8'h00);
    wr_reg(8'h04);
    chk("R6 write one", {7'd0, svc_irq}, 8'd0);
    @(negedge clk) chk("R6 write one later", {7'd0, svc_irq}, 8'd0);

    // R7 R8 R9 R10 exhaustive transitions
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        for (int e = 0; e < 2; e++) begin
          logic [2:0] sm, dm, em;
          logic lg, rel;
          sm = s[2:0]; dm = d[2:0];
          lg  = m_pio(sm) || m_pio(dm) || sm == dm;
          rel = m_hs(sm) && m_pio(dm);
          em  = lg ? dm : sm;
          do_reset();
          empty = 1'b1;
          wr_reg({sm, 5'b10100});
          empty = e[0];
          wr_reg({dm, 5'b10100});
          chk("R9 afd release", {7'd0, afd_rel}, {7'd0, rel});
          chk("R7 mode err", {7'd0, mode_err}, {7'd0, !lg});
          chk("R10 drain err", {7'd0, drain_err}, {7'd0, rel && !e[0]});
          chk("R8 hs enable", {7'd0, hs_en}, {7'd0, m_hs(em)});
          rd_reg(v);
          chk("R7 mode read", {5'd0, v[7:5]}, {5'd0, em});
          chk("R9 afd width", {7'd0, afd_rel}, 8'd0);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule